// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Store Controller

This block sits between a processor's register bus and a small byte-wide nonvolatile data store. It exposes five byte-wide locations: an address register, a data register, a control register, a key port and an interrupt register. Software reads the store through the read bit. To write, it loads the address and data, writes the two key bytes to the key port, and then writes the control register with the start and enable bits set. The write then runs for a fixed latency. The start bit stays high until the write is done, so software can poll it, and the end of the write raises an interrupt flag.

A separate port serves an external programmer. It reads and writes the store directly, but only while the protect input is low. Two conditions block every processor write: a power-up lockout counter that runs after power-on reset, and a warm reset. A warm reset that lands during a write aborts the write and records an error bit.

Top module: `nvm_write_guard`

## Requirements
- R1: After power-on reset (rst_n low) the control register (offset 2) and the interrupt register (offset 4) read 0x00, and both interrupt outputs are low.
- R2: For PWRT_CYCLES clock cycles after rst_n rises, no write starts, even after the full key sequence and a valid start write.
- R3: A write starts only when three bus accesses occur back to back: a write of 0x55 to the key port (offset 3), then a write of 0xAA to the key port, then a control write with bit 1 set. Any other access anywhere in that chain drops the chain, including a read, a write to another offset, a repeated 0x55, or the bytes in the wrong order.
- R4: The starting control write must also carry enable (bit 2) = 1, memory-select (bit 7) = 0 and config-select (bit 6) = 0. Otherwise no write starts, and the control register holds the written bits with bits 1 and 0 read as 0.
- R5: Once a write starts, control bit 1 reads 1 for exactly WR_LATENCY cycles and then clears by itself. The store then holds, at the captured address, the byte that the data register (offset 1) held at the start.
- R6: The key port reads 0x00 whatever was written to it.
- R7: A control write with bit 0 set loads the data register with the byte at the current address. Bit 0 reads 1 for one cycle only. The read is ignored while a write is in progress, and the data register keeps its value.
- R8: While ext_protect is 1, ext_ack is 0, ext_rdata is 0x00 and external writes change nothing. Processor-side writes still work. While ext_protect is 0, external reads return the stored byte and external writes store their byte.
- R9: Completion of a write sets interrupt bit 0. irq_lo = flag & enable (bit 1) & !priority (bit 2), and irq_hi = flag & enable & priority. Writing bit 0 as 0 clears the flag.
- R10: A warm_rst pulse during a write aborts it: the store stays unchanged, no completion flag is set, and control reads 0x08 (error bit 3 set; enable, start and select bits clear). Writing bit 3 as 0 clears the error.
- R11: An external write during a processor write is refused (ext_ack 0) and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (counts as a bus access) |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| ext_protect | input | 1 | External access protect |
| ext_we | input | 1 | External write strobe |
| ext_re | input | 1 | External read strobe |
| ext_addr | input | ADDR_W | External byte address |
| ext_wdata | input | 8 | External write data |
| ext_rdata | output | 8 | External read data |
| ext_ack | output | 1 | External access accepted |
| irq_hi | output | 1 | High-priority completion interrupt |
| irq_lo | output | 1 | Low-priority completion interrupt |

## Verification
The bench first sweeps every address with a full write followed by a read-back. It counts how many polling reads see the start bit set: a latency counter off by one gives a count other than WR_LATENCY. It then tries a set of broken key chains: a stray read between the keys, a doubled first key, swapped keys, and a data write between the second key and the start. A tracker that ignores reads, or that restarts on a repeated first key, would start a write and corrupt the store. The bench also fires the key sequence inside the power-up window, requests a read during a write, attempts external access under protect and during a write, and warm-resets in the middle of a write. A design that lets any of these through shows a wrong store byte, a wrong data register, a missing ack refusal, or a missing error bit.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;
   typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_ARMED} key_state_e;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   localparam logic [2:0] OFS_ADDR = 3'd0;
   localparam logic [2:0] OFS_DATA = 3'd1;
   localparam logic [2:0] OFS_CTRL = 3'd2;
   localparam logic [2:0] OFS_KEY  = 3'd3;
   localparam logic [2:0] OFS_IRQ  = 3'd4;

   localparam int CB_RD    = 0;
   localparam int CB_WR    = 1;
   localparam int CB_WREN  = 2;
   localparam int CB_WRERR = 3;
   localparam int CB_FREE  = 4;
   localparam int CB_CFG   = 6;
   localparam int CB_MSEL  = 7;

   localparam int IB_FLAG = 0;
   localparam int IB_EN   = 1;
   localparam int IB_PRIO = 2;
endpackage

// File: rtl/nvmw_pwrt.sv
module nvmw_pwrt #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic active
);
   localparam int CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);

   generate
      if (CYCLES == 0) begin : g_none
         assign active = 1'b0;
      end else begin : g_timer
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (cnt != CW'(CYCLES))
               cnt <= cnt + 1'b1;
         end
         assign active = (cnt != CW'(CYCLES));
      end
   endgenerate
endmodule

// File: rtl/nvmw_unlock.sv
module nvmw_unlock
   import nvmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic access,
   input  logic key1_wr,
   input  logic key2_wr,
   output logic armed
);
   key_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= KS_IDLE;
      else if (clr)
         st <= KS_IDLE;
      else if (access) begin
         unique case (st)
            KS_IDLE:  st <= key1_wr ? KS_HALF : KS_IDLE;
            KS_HALF:  st <= key2_wr ? KS_ARMED : KS_IDLE;
            default:  st <= KS_IDLE;
         endcase
      end
   end

   assign armed = (st == KS_ARMED);
endmodule

// File: rtl/nvmw_array.sv
module nvmw_array #(
   parameter int ADDR_W     = 8,
   parameter int WR_LATENCY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [7:0]        st_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              ext_we,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [7:0]        ext_wdata,
   output logic [7:0]        ext_rdata,
   output logic              busy,
   output logic              done
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CW    = $clog2(WR_LATENCY + 1);

   logic [7:0]        mem [DEPTH];
   logic [CW-1:0]     cnt;
   logic [ADDR_W-1:0] cap_addr;
   logic [7:0]        cap_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= CW'(WR_LATENCY);
      end else if (busy) begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1))
            busy <= 1'b0;
      end
   end

   assign done = busy && (cnt == CW'(1)) && !abort;

   always_ff @(posedge clk) begin
      if (start && !busy) begin
         cap_addr <= st_addr;
         cap_data <= st_data;
      end
      if (done)
         mem[cap_addr] <= cap_data;
      else if (ext_we && !busy)
         mem[ext_addr] <= ext_wdata;
   end

   assign rd_data   = mem[rd_addr];
   assign ext_rdata = mem[ext_addr];
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
   import nvmw_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int WR_LATENCY  = 4,
   parameter int PWRT_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm_rst,
   input  logic              cpu_we,
   input  logic              cpu_re,
   input  logic [2:0]        cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   input  logic              ext_protect,
   input  logic              ext_we,
   input  logic              ext_re,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [7:0]        ext_wdata,
   output logic [7:0]        ext_rdata,
   output logic              ext_ack,
   output logic              irq_hi,
   output logic              irq_lo
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
         $error("nvm_write_guard: ADDR_W must lie in 1..8");
      end
      if (WR_LATENCY < 1) begin : g_bad_latency
         $error("nvm_write_guard: WR_LATENCY must be at least 1");
      end
      if (PWRT_CYCLES < 0) begin : g_bad_pwrt
         $error("nvm_write_guard: PWRT_CYCLES must not be negative");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic              msel_q, cfg_q, free_q, wren_q, wrerr, rd_pulse;
   logic              int_flag, int_en, int_prio;
   logic              pwrt_active, armed, wr_start, wr_busy, wr_done;
   logic [7:0]        arr_rd, arr_ext;
   logic              addr_wr, data_wr, ctrl_wr, irq_wr, key1_wr, key2_wr;
   logic              rd_go, ext_open, ext_store;

   assign addr_wr = cpu_we && (cpu_addr == OFS_ADDR);
   assign data_wr = cpu_we && (cpu_addr == OFS_DATA);
   assign ctrl_wr = cpu_we && (cpu_addr == OFS_CTRL);
   assign irq_wr  = cpu_we && (cpu_addr == OFS_IRQ);
   assign key1_wr = cpu_we && (cpu_addr == OFS_KEY) && (cpu_wdata == KEY_FIRST);
   assign key2_wr = cpu_we && (cpu_addr == OFS_KEY) && (cpu_wdata == KEY_SECOND);

   nvmw_pwrt #(.CYCLES(PWRT_CYCLES)) u_pwrt (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (pwrt_active)
   );

   nvmw_unlock u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (warm_rst),
      .access  (cpu_we || cpu_re),
      .key1_wr (key1_wr),
      .key2_wr (key2_wr),
      .armed   (armed)
   );

   assign wr_start = ctrl_wr && armed && !warm_rst && !pwrt_active && !wr_busy
                     && cpu_wdata[CB_WR] && cpu_wdata[CB_WREN]
                     && !cpu_wdata[CB_MSEL] && !cpu_wdata[CB_CFG];

   assign ext_open  = !ext_protect;
   assign ext_store = ext_open && ext_we && !wr_busy;

   nvmw_array #(.ADDR_W(ADDR_W), .WR_LATENCY(WR_LATENCY)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (warm_rst),
      .start     (wr_start),
      .st_addr   (addr_q),
      .st_data   (data_q),
      .rd_addr   (addr_q),
      .rd_data   (arr_rd),
      .ext_we    (ext_store),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .ext_rdata (arr_ext),
      .busy      (wr_busy),
      .done      (wr_done)
   );

   assign rd_go = ctrl_wr && cpu_wdata[CB_RD] && !wr_busy && !rd_pulse && !warm_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (addr_wr)
            addr_q <= cpu_wdata[ADDR_W-1:0];
         if (data_wr)
            data_q <= cpu_wdata;
         else if (rd_go)
            data_q <= arr_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msel_q   <= 1'b0;
         cfg_q    <= 1'b0;
         free_q   <= 1'b0;
         wren_q   <= 1'b0;
         wrerr    <= 1'b0;
         rd_pulse <= 1'b0;
      end else if (warm_rst) begin
         msel_q   <= 1'b0;
         cfg_q    <= 1'b0;
         free_q   <= 1'b0;
         wren_q   <= 1'b0;
         wrerr    <= wrerr | wr_busy;
         rd_pulse <= 1'b0;
      end else begin
         rd_pulse <= rd_go;
         if (ctrl_wr) begin
            msel_q <= cpu_wdata[CB_MSEL];
            cfg_q  <= cpu_wdata[CB_CFG];
            free_q <= cpu_wdata[CB_FREE];
            wren_q <= cpu_wdata[CB_WREN];
            wrerr  <= cpu_wdata[CB_WRERR];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_flag <= 1'b0;
         int_en   <= 1'b0;
         int_prio <= 1'b0;
      end else begin
         if (wr_done)
            int_flag <= 1'b1;
         else if (irq_wr)
            int_flag <= cpu_wdata[IB_FLAG];
         if (irq_wr) begin
            int_en   <= cpu_wdata[IB_EN];
            int_prio <= cpu_wdata[IB_PRIO];
         end
      end
   end

   always_comb begin
      cpu_rdata = 8'h00;
      unique case (cpu_addr)
         OFS_ADDR: cpu_rdata = 8'(addr_q);
         OFS_DATA: cpu_rdata = data_q;
         OFS_CTRL: cpu_rdata = {msel_q, cfg_q, 1'b0, free_q, wrerr, wren_q, wr_busy, rd_pulse};
         OFS_IRQ:  cpu_rdata = {5'b0, int_prio, int_en, int_flag};
         default:  cpu_rdata = 8'h00;
      endcase
   end

   assign ext_ack   = ext_open && (ext_re || (ext_we && !wr_busy));
   assign ext_rdata = (ext_open && ext_re) ? arr_ext : 8'h00;

   assign irq_hi = int_flag && int_en && int_prio;
   assign irq_lo = int_flag && int_en && !int_prio;
endmodule

// File: rtl/nvmw_chk.sv
module nvmw_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       warm_rst,
   input logic       pwrt_active,
   input logic       armed,
   input logic       wr_start,
   input logic       wr_busy,
   input logic       wr_done,
   input logic       rd_pulse,
   input logic       wrerr,
   input logic       int_flag,
   input logic       ext_protect,
   input logic       ext_we,
   input logic       ext_ack,
   input logic [7:0] ext_rdata,
   input logic       irq_hi,
   input logic       irq_lo
);
   // R2
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwrt_active |-> !wr_start);

   // R3
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> armed);

   // R5
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> wr_busy);

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pulse |=> !rd_pulse);

   // R7
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |=> !rd_pulse);

   // R8
   protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_protect |-> (!ext_ack && ext_rdata == 8'h00));

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && !warm_rst) |=> int_flag);

   // R9
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_hi, irq_lo}));

   // R10
   abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_rst && wr_busy) |=> (wrerr && !wr_busy));

   // R11
   ext_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && ext_we) |-> !ext_ack);
endmodule

bind nvm_write_guard nvmw_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .warm_rst    (warm_rst),
   .pwrt_active (pwrt_active),
   .armed       (armed),
   .wr_start    (wr_start),
   .wr_busy     (wr_busy),
   .wr_done     (wr_done),
   .rd_pulse    (rd_pulse),
   .wrerr       (wrerr),
   .int_flag    (int_flag),
   .ext_protect (ext_protect),
   .ext_we      (ext_we),
   .ext_ack     (ext_ack),
   .ext_rdata   (ext_rdata),
   .irq_hi      (irq_hi),
   .irq_lo      (irq_lo)
);

// File: tb/tb_nvm_write_guard.sv
module tb_nvm_write_guard;
   localparam int CLK_P = 10;
   localparam int AW    = 4;
   localparam int LAT   = 3;
   localparam int PWRT  = 20;
   localparam int DEPTH = 1 << AW;

   localparam logic [2:0] A_ADDR = 3'd0, A_DATA = 3'd1, A_CTRL = 3'd2, A_KEY = 3'd3, A_IRQ = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic warm_rst = 1'b0;
   logic cpu_we = 1'b0, cpu_re = 1'b0;
   logic [2:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic ext_protect = 1'b0, ext_we = 1'b0, ext_re = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [7:0] ext_wdata = '0;
   logic [7:0] ext_rdata;
   logic ext_ack, irq_hi, irq_lo;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_mem [DEPTH];

   always #(CLK_P/2) clk = ~clk;

   nvm_write_guard #(.ADDR_W(AW), .WR_LATENCY(LAT), .PWRT_CYCLES(PWRT)) dut (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .ext_protect(ext_protect), .ext_we(ext_we), .ext_re(ext_re),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ext_ack(ext_ack), .irq_hi(irq_hi), .irq_lo(irq_lo)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(posedge clk); #1;
      cpu_we = 1'b0;
   endtask

   task automatic cpu_rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      cpu_re = 1'b1; cpu_addr = a;
      #1 v = cpu_rdata;
      @(posedge clk); #1;
      cpu_re = 1'b0;
   endtask

   task automatic ext_rd(input logic [AW-1:0] a, output logic [7:0] d, output logic ack);
      @(negedge clk);
      ext_re = 1'b1; ext_addr = a;
      #1 d = ext_rdata; ack = ext_ack;
      @(posedge clk); #1;
      ext_re = 1'b0;
   endtask

   task automatic ext_wr(input logic [AW-1:0] a, input logic [7:0] d, output logic ack);
      @(negedge clk);
      ext_we = 1'b1; ext_addr = a; ext_wdata = d;
      #1 ack = ext_ack;
      @(posedge clk); #1;
      ext_we = 1'b0;
   endtask

   task automatic full_write(input logic [AW-1:0] a, input logic [7:0] d);
      cpu_wr(A_ADDR, 8'(a));
      cpu_wr(A_DATA, d);
      cpu_wr(A_KEY, 8'h55);
      cpu_wr(A_KEY, 8'hAA);
      cpu_wr(A_CTRL, 8'h06);
   endtask

   task automatic settle();
      repeat (LAT + 2) @(posedge clk);
      #1;
   endtask

   task automatic mem_check(input string req, input logic [AW-1:0] a);
      logic [7:0] d;
      logic ack;
      ext_rd(a, d, ack);
      check(req, d, exp_mem[a]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v, d;
      logic ack;
      int busy_n;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      cpu_rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
      cpu_rd(A_IRQ, v);  check("R1 irq reg", v, 8'h00);
      check("R1 irq pins", {6'b0, irq_hi, irq_lo}, 8'h00);

      // R2 key sequence inside the power-up window
      full_write(4'd5, 8'h11);
      cpu_rd(A_CTRL, v); check("R2 no start in lockout", v, 8'h04);
      settle();
      cpu_rd(A_IRQ, v);  check("R2 no completion", v, 8'h00);
      repeat (PWRT + 5) @(posedge clk);

      // R5 sweep over every address, R7 and R8 read back
      for (int a = 0; a < DEPTH; a++) begin
         logic [7:0] val;
         val = 8'((a * 37 + 11) ^ 8'h5C);
         full_write(AW'(a), val);
         busy_n = 0;
         for (int k = 0; k < 20; k++) begin
            cpu_rd(A_CTRL, v);
            if (!v[1]) break;
            busy_n++;
         end
         check("R5 busy cycles", 8'(busy_n), 8'(LAT));
         exp_mem[a] = val;
         cpu_rd(A_IRQ, v); check("R9 flag on completion", v & 8'h01, 8'h01);
         cpu_wr(A_IRQ, 8'h00);
         cpu_wr(A_DATA, 8'h00);
         cpu_wr(A_CTRL, 8'h05);
         cpu_rd(A_CTRL, v); check("R7 read bit high", v, 8'h05);
         cpu_rd(A_CTRL, v); check("R7 read bit cleared", v, 8'h04);
         cpu_rd(A_DATA, v); check("R5 R7 stored byte", v, val);
         mem_check("R8 external read", AW'(a));
      end

      // R3 broken chains, target address 3
      cpu_wr(A_ADDR, 8'd3); cpu_wr(A_DATA, ~exp_mem[3]);
      cpu_wr(A_KEY, 8'h55); cpu_rd(A_ADDR, v); cpu_wr(A_KEY, 8'hAA); cpu_wr(A_CTRL, 8'h06);
      cpu_rd(A_CTRL, v); check("R3 read between keys", v, 8'h04);
      cpu_wr(A_KEY, 8'h55); cpu_wr(A_KEY, 8'h55); cpu_wr(A_KEY, 8'hAA); cpu_wr(A_CTRL, 8'h06);
      cpu_rd(A_CTRL, v); check("R3 doubled first key", v, 8'h04);
      cpu_wr(A_KEY, 8'hAA); cpu_wr(A_KEY, 8'h55); cpu_wr(A_CTRL, 8'h06);
      cpu_rd(A_CTRL, v); check("R3 swapped keys", v, 8'h04);
      cpu_wr(A_KEY, 8'h55); cpu_wr(A_KEY, 8'hAA); cpu_wr(A_DATA, ~exp_mem[3]); cpu_wr(A_CTRL, 8'h06);
      cpu_rd(A_CTRL, v); check("R3 access before start", v, 8'h04);
      settle();
      mem_check("R3 store unchanged", 4'd3);

      // R4 start with bad control bits
      cpu_wr(A_KEY, 8'h55); cpu_wr(A_KEY, 8'hAA); cpu_wr(A_CTRL, 8'h02);
      cpu_rd(A_CTRL, v); check("R4 enable clear", v, 8'h00);
      cpu_wr(A_KEY, 8'h55); cpu_wr(A_KEY, 8'hAA); cpu_wr(A_CTRL, 8'h86);
      cpu_rd(A_CTRL, v); check("R4 memory select", v, 8'h84);
      cpu_wr(A_KEY, 8'h55); cpu_wr(A_KEY, 8'hAA); cpu_wr(A_CTRL, 8'h46);
      cpu_rd(A_CTRL, v); check("R4 config select", v, 8'h44);
      settle();
      mem_check("R4 store unchanged", 4'd3);
      cpu_rd(A_IRQ, v); check("R4 no completion", v, 8'h00);

      // R6 key port reads zero
      cpu_wr(A_KEY, 8'h55);
      cpu_rd(A_KEY, v); check("R6 key port read", v, 8'h00);

      // R7 read request during a write
      full_write(4'd6, ~exp_mem[6]);
      cpu_wr(A_CTRL, 8'h05);
      cpu_rd(A_CTRL, v); check("R7 read ignored while busy", v, 8'h06);
      cpu_rd(A_DATA, v); check("R7 data reg kept", v, ~exp_mem[6]);
      settle();
      exp_mem[6] = ~exp_mem[6];
      mem_check("R5 write after ignored read", 4'd6);
      cpu_wr(A_IRQ, 8'h00);

      // R8 protection
      ext_protect = 1'b1;
      ext_rd(4'd3, d, ack);
      check("R8 protected read ack", {7'b0, ack}, 8'h00);
      check("R8 protected read data", d, 8'h00);
      ext_wr(4'd3, 8'hE7, ack);
      check("R8 protected write ack", {7'b0, ack}, 8'h00);
      full_write(4'd9, 8'h3C);
      settle();
      exp_mem[9] = 8'h3C;
      ext_protect = 1'b0;
      mem_check("R8 protected write dropped", 4'd3);
      mem_check("R8 cpu write under protect", 4'd9);
      ext_wr(4'd10, 8'h5A, ack);
      check("R8 open write ack", {7'b0, ack}, 8'h01);
      exp_mem[10] = 8'h5A;
      cpu_wr(A_ADDR, 8'd10); cpu_wr(A_CTRL, 8'h01);
      cpu_rd(A_DATA, v); check("R8 external byte seen by cpu", v, 8'h5A);
      cpu_wr(A_IRQ, 8'h00);

      // R11 external write during a processor write
      full_write(4'd2, ~exp_mem[2]);
      ext_wr(4'd2, 8'h33, ack);
      check("R11 ack refused", {7'b0, ack}, 8'h00);
      settle();
      exp_mem[2] = ~exp_mem[2];
      mem_check("R11 store holds cpu byte", 4'd2);

      // R9 interrupt routing
      cpu_wr(A_IRQ, 8'h02);
      full_write(4'd1, 8'h81);
      settle();
      exp_mem[1] = 8'h81;
      check("R9 low priority pins", {6'b0, irq_hi, irq_lo}, 8'h01);
      cpu_wr(A_IRQ, 8'h06);
      check("R9 flag cleared", {6'b0, irq_hi, irq_lo}, 8'h00);
      full_write(4'd1, 8'h18);
      settle();
      exp_mem[1] = 8'h18;
      check("R9 high priority pins", {6'b0, irq_hi, irq_lo}, 8'h02);
      cpu_wr(A_IRQ, 8'h00);

      // R10 warm reset during a write
      full_write(4'd12, ~exp_mem[12]);
      @(negedge clk) warm_rst = 1'b1;
      @(posedge clk); #1 warm_rst = 1'b0;
      cpu_rd(A_CTRL, v); check("R10 error after abort", v, 8'h08);
      settle();
      mem_check("R10 store unchanged", 4'd12);
      cpu_rd(A_IRQ, v); check("R10 no completion", v, 8'h00);
      cpu_wr(A_CTRL, 8'h00);
      cpu_rd(A_CTRL, v); check("R10 error cleared", v, 8'h00);

      summary();
      $finish;
   end
endmodule